// File: doc/BRIEF.md
# DRAM Controller Operating-State Manager

This block holds the operating state of a DRAM controller and decides which requests may move it. The four states are Config, Ready, Paused and Low_power. There are two ways to request a change. The first is a command code written through the register path, qualified by a valid strobe. The second is a low-power handshake: a request input that the block answers with an accept pulse or a deny pulse. Before it makes a move, the block looks at an idle indication from the datapath and a flag that says all direct memory commands have finished.

From the current state the block drives three outputs: a state code, a hold signal that keeps the arbiter from issuing unarbitrated accesses, and an enable for refresh generation. It records whether Low_power was entered through the handshake or through the register path, and it allows Low_power to be left only through the same path. Right after reset there is a short start-up window. During that window the block reports a Starting code, ignores commands and denies handshake requests.

Top module: `mc_opstate_mgr`

## Requirements
- R1: While reset is asserted, and for the two clock cycles after it is released, `state_o` reads 4 (Starting). During that window every command is ignored and every `lp_req` is answered with a deny. From the third cycle on, `state_o` reads 0 (Config).
- R2: The command codes are 0 Go, 1 Sleep, 2 Wakeup, 3 Pause, 4 Configure and 5 Active_Pause. Codes 6 and 7 never change the state.
- R3: In Config, Go moves the state to Ready (code 1) only when `dp_idle` and `direct_done` are both high. Without both, Go is ignored.
- R4: In Ready, with `dp_idle` high, three commands are accepted. Configure goes to Config, Pause goes to Paused (code 2) and Sleep goes to Low_power (code 3). Each of them is ignored while `dp_idle` is low.
- R5: In Ready, Active_Pause moves the state to Paused whatever the value of `dp_idle`. In Paused, Go returns to Ready when `dp_idle` is high.
- R6: In Paused, Configure moves to Config only when `dp_idle` is high and Paused was entered through Pause. If Paused was entered through Active_Pause, Configure is ignored.
- R7: `arb_hold` is low only in Ready. `refresh_en` is high only in Ready or Paused, so it is low in Config, Low_power and Starting.
- R8: An `lp_req` in Ready with `dp_idle` high, arriving in a cycle where no command is accepted, moves the state to Low_power and sets `lp_via_hs`. `lp_accept` pulses for one cycle, one cycle after the state changes.
- R9: An `lp_req` that is not allowed leaves the state unchanged. It produces a one-cycle `lp_deny` pulse in the cycle after the request. A request is not allowed in Config or Paused, in Ready with `dp_idle` low, or when a command is accepted in the same cycle.
- R10: Low_power is left only through the path that entered it. After a handshake entry, `lp_req` returns the state to Ready and Wakeup is ignored. After a register entry, Wakeup with `dp_idle` high returns it to Ready and `lp_req` is denied.
- R11: Any command that is not legal in the current state, or whose idle or completion conditions are not met, leaves the state and all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe from the register path |
| cmd_code | input | 3 | Command code |
| lp_req | input | 1 | Low-power handshake request |
| dp_idle | input | 1 | Datapath idle indication |
| direct_done | input | 1 | All direct commands have completed |
| state_o | output | 3 | 0 Config, 1 Ready, 2 Paused, 3 Low_power, 4 Starting |
| arb_hold | output | 1 | Hold unarbitrated accesses in the arbiter |
| refresh_en | output | 1 | Refresh generation enable |
| lp_accept | output | 1 | Handshake accept pulse |
| lp_deny | output | 1 | Handshake deny pulse |
| lp_via_hs | output | 1 | High in Low_power when it was entered through the handshake |

## Verification
The hardest situation to reach from the ports is a Configure command that arrives in Paused when Paused was entered through Active_Pause. A random walk seldom produces that exact order, and it also has to meet a busy datapath. The other hard situation is a wrong-path exit from Low_power, which needs a specific entry path followed by the opposite wakeup. Directed sequences build both cases explicitly. They also cover the start-up window and the collision between a command and a handshake request in the same cycle. A seeded random walk then mixes all of the inputs against a bench model.

// File: rtl/mcsm_pkg.sv
package mcsm_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [1:0] {
        ST_CFG = 2'd0,
        ST_RDY = 2'd1,
        ST_PSE = 2'd2,
        ST_LP  = 2'd3
    } op_state_e;

    localparam logic [2:0] OBS_STARTING = 3'd4;

    localparam logic [CMD_W-1:0] C_GO     = 3'd0;
    localparam logic [CMD_W-1:0] C_SLEEP  = 3'd1;
    localparam logic [CMD_W-1:0] C_WAKE   = 3'd2;
    localparam logic [CMD_W-1:0] C_PAUSE  = 3'd3;
    localparam logic [CMD_W-1:0] C_CONF   = 3'd4;
    localparam logic [CMD_W-1:0] C_APAUSE = 3'd5;

    typedef struct packed {
        logic      take;
        op_state_e nxt;
        logic      via_apause;
    } cmd_dec_t;

    // Decides whether a register command is legal in the current state and where it goes.
    function automatic cmd_dec_t decode_cmd(
        input op_state_e            cur,
        input logic [CMD_W-1:0]     code,
        input logic                 idle,
        input logic                 ddone,
        input logic                 apause,
        input logic                 hs_entry
    );
        cmd_dec_t d;
        d.take       = 1'b0;
        d.nxt        = cur;
        d.via_apause = 1'b0;
        unique case (cur)
            ST_CFG: begin
                if (code == C_GO && idle && ddone) begin
                    d.take = 1'b1; d.nxt = ST_RDY;
                end
            end
            ST_RDY: begin
                if (code == C_APAUSE) begin
                    d.take = 1'b1; d.nxt = ST_PSE; d.via_apause = 1'b1;
                end else if (idle && code == C_PAUSE) begin
                    d.take = 1'b1; d.nxt = ST_PSE;
                end else if (idle && code == C_CONF) begin
                    d.take = 1'b1; d.nxt = ST_CFG;
                end else if (idle && code == C_SLEEP) begin
                    d.take = 1'b1; d.nxt = ST_LP;
                end
            end
            ST_PSE: begin
                if (idle && code == C_GO) begin
                    d.take = 1'b1; d.nxt = ST_RDY;
                end else if (idle && code == C_CONF && !apause) begin
                    d.take = 1'b1; d.nxt = ST_CFG;
                end
            end
            ST_LP: begin
                if (idle && code == C_WAKE && !hs_entry) begin
                    d.take = 1'b1; d.nxt = ST_RDY;
                end
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mcsm_warmup.sv
module mcsm_warmup #(
    parameter int WARM_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    localparam int CW = $clog2(WARM_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WARM_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign ready = (cnt_q == LIMIT);
endmodule

// File: rtl/mcsm_fsm.sv
module mcsm_fsm
    import mcsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ready,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             lp_req,
    input  logic             dp_idle,
    input  logic             direct_done,
    output op_state_e        state,
    output logic             act_pause,
    output logic             hs_entry,
    output logic             hs_take,
    output logic             hs_refuse
);
    op_state_e state_q;
    logic      apause_q;
    logic      hs_entry_q;
    cmd_dec_t  dec;
    logic      cmd_take;
    logic      hs_ok;

    always_comb begin
        dec      = decode_cmd(state_q, cmd_code, dp_idle, direct_done, apause_q, hs_entry_q);
        cmd_take = ready && cmd_valid && dec.take;
        hs_ok    = ready && lp_req && !cmd_take &&
                   ((state_q == ST_RDY && dp_idle) || (state_q == ST_LP && hs_entry_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_CFG;
            apause_q   <= 1'b0;
            hs_entry_q <= 1'b0;
        end else if (cmd_take) begin
            state_q    <= dec.nxt;
            apause_q   <= dec.via_apause;
            hs_entry_q <= 1'b0;
        end else if (hs_ok) begin
            state_q    <= (state_q == ST_RDY) ? ST_LP : ST_RDY;
            apause_q   <= 1'b0;
            hs_entry_q <= (state_q == ST_RDY);
        end
    end

    assign state     = state_q;
    assign act_pause = apause_q;
    assign hs_entry  = hs_entry_q;
    assign hs_take   = hs_ok;
    assign hs_refuse = lp_req && !hs_ok;
endmodule

// File: rtl/mcsm_hs_resp.sv
module mcsm_hs_resp (
    input  logic clk,
    input  logic rst,
    input  logic hs_take,
    input  logic hs_refuse,
    output logic accept,
    output logic deny
);
    logic pend_q, acc_q, deny_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            acc_q  <= 1'b0;
            deny_q <= 1'b0;
        end else begin
            pend_q <= hs_take;
            acc_q  <= pend_q;
            deny_q <= hs_refuse;
        end
    end

    assign accept = acc_q;
    assign deny   = deny_q;
endmodule

// File: rtl/mc_opstate_mgr.sv
module mc_opstate_mgr
    import mcsm_pkg::*;
#(
    parameter int WARM_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       lp_req,
    input  logic       dp_idle,
    input  logic       direct_done,
    output logic [2:0] state_o,
    output logic       arb_hold,
    output logic       refresh_en,
    output logic       lp_accept,
    output logic       lp_deny,
    output logic       lp_via_hs
);
    logic      ready;
    op_state_e st;
    logic      act_pause;
    logic      hs_entry;
    logic      hs_take;
    logic      hs_refuse;

    mcsm_warmup #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
        .clk   (clk),
        .rst   (rst),
        .ready (ready)
    );

    mcsm_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ready       (ready),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .lp_req      (lp_req),
        .dp_idle     (dp_idle),
        .direct_done (direct_done),
        .state       (st),
        .act_pause   (act_pause),
        .hs_entry    (hs_entry),
        .hs_take     (hs_take),
        .hs_refuse   (hs_refuse)
    );

    mcsm_hs_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .hs_take   (hs_take),
        .hs_refuse (hs_refuse),
        .accept    (lp_accept),
        .deny      (lp_deny)
    );

    always_comb begin
        state_o    = ready ? {1'b0, st} : OBS_STARTING;
        arb_hold   = !(ready && st == ST_RDY);
        refresh_en = ready && (st == ST_RDY || st == ST_PSE);
        lp_via_hs  = ready && st == ST_LP && hs_entry;
    end
endmodule

// File: rtl/mcsm_chk.sv
module mcsm_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       lp_req,
    input logic       dp_idle,
    input logic       direct_done,
    input logic [2:0] state_o,
    input logic       arb_hold,
    input logic       refresh_en,
    input logic       lp_accept,
    input logic       lp_deny,
    input logic       lp_via_hs,
    input logic       act_pause
);
    // R9
    acc_deny_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lp_accept && lp_deny));

    // R8
    accept_after_move_chk: assert property (@(posedge clk) disable iff (rst)
        lp_accept |-> ($past(state_o) != $past(state_o, 2)));

    // R3
    cfg_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == 3'd0 && state_o != 3'd0) |->
            (state_o == 3'd1 && $past(dp_idle) && $past(direct_done)));

    // R6
    apause_no_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == 3'd2 && state_o == 3'd0) |-> !$past(act_pause));

    // R7
    refresh_state_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_en |-> (state_o == 3'd1 || state_o == 3'd2));

    // R7
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !arb_hold |-> state_o == 3'd1);

    // R10
    lp_exit_path_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == 3'd3 && state_o != 3'd3) |->
            ($past(lp_via_hs) ? $past(lp_req)
                              : ($past(cmd_valid) && $past(cmd_code) == 3'd2)));

    // R8
    lp_entry_from_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) != 3'd3 && state_o == 3'd3) |-> $past(state_o) == 3'd1);
endmodule

bind mc_opstate_mgr mcsm_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .lp_req      (lp_req),
    .dp_idle     (dp_idle),
    .direct_done (direct_done),
    .state_o     (state_o),
    .arb_hold    (arb_hold),
    .refresh_en  (refresh_en),
    .lp_accept   (lp_accept),
    .lp_deny     (lp_deny),
    .lp_via_hs   (lp_via_hs),
    .act_pause   (act_pause)
);

// File: tb/mc_opstate_mgr_tb.sv
module mc_opstate_mgr_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       lp_req = 1'b0;
    logic       dp_idle = 1'b1;
    logic       direct_done = 1'b1;
    logic [2:0] state_o;
    logic       arb_hold, refresh_en, lp_accept, lp_deny, lp_via_hs;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    int   m_warm;
    int   m_st;     // 0 cfg 1 rdy 2 pse 3 lp
    bit   m_ap, m_hs, m_pend, m_acc, m_deny;

    always #5 clk = ~clk;

    mc_opstate_mgr u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .lp_req(lp_req), .dp_idle(dp_idle), .direct_done(direct_done),
        .state_o(state_o), .arb_hold(arb_hold), .refresh_en(refresh_en),
        .lp_accept(lp_accept), .lp_deny(lp_deny), .lp_via_hs(lp_via_hs)
    );

    function automatic int exp_state();
        return (m_warm < 2) ? 4 : m_st;
    endfunction

    task automatic model_reset();
        m_warm = 0; m_st = 0; m_ap = 0; m_hs = 0; m_pend = 0; m_acc = 0; m_deny = 0;
    endtask

    task automatic model_step(bit cv, int code, bit lr, bit idle, bit dd);
        bit rdy = (m_warm >= 2);
        bit take = 0; int nx = m_st; bit nap = 0; bit hok;
        if (rdy && cv) begin
            case (m_st)
                0: if (code == 0 && idle && dd) begin take = 1; nx = 1; end
                1: if (code == 5) begin take = 1; nx = 2; nap = 1; end
                   else if (idle && code == 3) begin take = 1; nx = 2; end
                   else if (idle && code == 4) begin take = 1; nx = 0; end
                   else if (idle && code == 1) begin take = 1; nx = 3; end
                2: if (idle && code == 0) begin take = 1; nx = 1; end
                   else if (idle && code == 4 && !m_ap) begin take = 1; nx = 0; end
                default: if (idle && code == 2 && !m_hs) begin take = 1; nx = 1; end
            endcase
        end
        hok = rdy && lr && !take && ((m_st == 1 && idle) || (m_st == 3 && m_hs));
        m_acc  = m_pend;
        m_pend = hok;
        m_deny = lr && !hok;
        if (take) begin m_st = nx; m_ap = nap; m_hs = 0; end
        else if (hok) begin m_hs = (m_st == 1); m_st = (m_st == 1) ? 3 : 1; m_ap = 0; end
        if (m_warm < 2) m_warm++;
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int es = exp_state();
        cmp(tag, "state_o", int'(state_o), es);
        cmp("R7", "arb_hold", int'(arb_hold), (es == 1) ? 0 : 1);
        cmp("R7", "refresh_en", int'(refresh_en), (es == 1 || es == 2) ? 1 : 0);
        cmp(tag, "lp_via_hs", int'(lp_via_hs), (es == 3 && m_hs) ? 1 : 0);
        cmp(tag, "lp_accept", int'(lp_accept), int'(m_acc));
        cmp(tag, "lp_deny", int'(lp_deny), int'(m_deny));
    endtask

    // drive at negedge, apply at posedge, check at next negedge
    task automatic step(string tag, bit cv, int code, bit lr, bit idle, bit dd);
        cmd_valid = cv; cmd_code = 3'(code); lp_req = lr; dp_idle = idle; direct_done = dd;
        @(posedge clk);
        model_step(cv, code, lr, idle, dd);
        @(negedge clk);
        cmd_valid = 0; lp_req = 0;
        check_all(tag);
    endtask

    task automatic do_reset();
        rst = 1; cmd_valid = 0; lp_req = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        check_all("R1");
        rst = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        @(negedge clk);
        do_reset();
        // R1: warm-up window ignores Go and denies lp_req
        step("R1", 1, 0, 1, 1, 1);
        step("R1", 1, 0, 1, 1, 1);
        step("R1", 0, 0, 0, 1, 1);
        // R3: Go without done or busy ignored, then accepted
        step("R3", 1, 0, 0, 1, 0);
        step("R3", 1, 0, 0, 0, 1);
        // R2: unused codes ignored
        step("R2", 1, 6, 0, 1, 1);
        step("R2", 1, 7, 0, 1, 1);
        step("R3", 1, 0, 0, 1, 1);
        // R11: illegal in Ready (Wakeup), R9 deny when busy
        step("R11", 1, 2, 0, 1, 1);
        step("R9", 0, 0, 1, 0, 1);
        // R4: Pause busy ignored, then Pause, Go back
        step("R4", 1, 3, 0, 0, 1);
        step("R4", 1, 3, 0, 1, 1);
        step("R9", 0, 0, 1, 1, 1);
        step("R5", 1, 0, 0, 1, 1);
        // R5/R6: Active_Pause while busy, Configure refused, Go
        step("R5", 1, 5, 0, 0, 1);
        step("R6", 1, 4, 0, 1, 1);
        step("R5", 1, 0, 0, 1, 1);
        // R6: Pause then Configure accepted
        step("R6", 1, 3, 0, 1, 1);
        step("R6", 1, 4, 0, 1, 1);
        step("R3", 1, 0, 0, 1, 1);
        // R8: handshake entry, accept pulse timing
        step("R8", 0, 0, 1, 1, 1);
        step("R8", 0, 0, 0, 1, 1);
        step("R8", 0, 0, 0, 1, 1);
        // R10: Wakeup ignored after handshake entry, lp_req exits
        step("R10", 1, 2, 0, 1, 1);
        step("R10", 0, 0, 1, 1, 1);
        step("R10", 0, 0, 0, 1, 1);
        // R10: register entry, lp_req denied, Wakeup exits
        step("R4", 1, 1, 0, 1, 1);
        step("R10", 0, 0, 1, 1, 1);
        step("R10", 1, 2, 0, 1, 1);
        // R9: collision, command wins
        step("R9", 1, 3, 1, 1, 1);
        step("R5", 1, 0, 0, 1, 1);
        // Random walk
        for (int i = 0; i < 4000; i++) begin
            bit cv  = ($urandom % 2) == 0;
            int c   = $urandom % 8;
            bit lr  = ($urandom % 4) == 0;
            bit idl = ($urandom % 4) != 0;
            bit dd  = ($urandom % 4) != 0;
            step("R11", cv, c, lr, idl, dd);
            if ((i % 1000) == 999) begin
                do_reset();
                step("R1", 1, 0, 1, 1, 1);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule